// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is an arithmetic and logic slice that adds, subtracts, ANDs, ORs or XORs two operands. It works either at the full data width or on the low byte alone. The result comes out combinationally from the current operands. A small status register holds five condition bits: carry, parity, zero, sign and overflow. That register loads the flags of the current operation on a rising clock edge, but only when the flag write enable is high.

In subtraction the carry bit reports a borrow. Parity always looks at the low byte of the result, even at the full width. Sign, zero, carry and overflow follow the selected width. Operands and op code are plain level inputs with no handshake. A new operation may be presented every cycle. The result is valid in the same cycle. The flags appear one edge later.

Top module: `alu_status_unit`

## Requirements
- R1: Op code `op_i` selects the operation: 0 add, 1 subtract (A minus B), 2 bitwise AND, 3 bitwise OR, 4 bitwise XOR. Codes 5, 6 and 7 are reserved and give an all-zero result.
- R2: `wide_i`=1 selects the full 16-bit width. `wide_i`=0 selects 8-bit mode: only operand bits 7:0 are used, and result bits 15:8 are zero.
- R3: For addition, carry is set on a carry out of the top bit of the selected width. For subtraction, carry is set when a borrow is needed, that is when unsigned A is less than unsigned B at that width.
- R4: For add and subtract, overflow is set when the true signed result does not fit in the selected width. Examples: 8-bit 7Fh+01h sets it, and 16-bit 8000h-0001h sets it.
- R5: Parity is set when bits 7:0 of the result hold an even number of ones, in both width modes.
- R6: Zero is set when the result at the selected width is all zeros.
- R7: Sign equals result bit 7 in 8-bit mode and result bit 15 in 16-bit mode.
- R8: AND, OR, XOR and the reserved codes clear carry and overflow.
- R9: The flag outputs take the flags of the current operation at a rising clock edge where `flag_we_i`=1. At an edge where it is 0 they keep their previous value.
- R10: When `rst_n` is low, all five flags are cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| op_i | input | 3 | Operation code (R1) |
| wide_i | input | 1 | 1: 16-bit, 0: 8-bit |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 16 | Combinational result |
| carry_o | output | 1 | Carry / borrow flag |
| parity_o | output | 1 | Even parity of result low byte |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| overflow_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the block with its defaults: a 16-bit data width and an 8-bit narrow width. This puts both carry positions (bit 8 and bit 16) and both sign positions (bit 7 and bit 15) within reach of directed vectors. Those vectors cover the 8-bit wrap cases FFh+01h, 00h-01h and 7Fh+01h, and their 16-bit counterparts. A 16-bit result with a zero low byte shows that parity ignores the high byte. Random operations with garbage in the upper operand byte, in 8-bit mode, show that those bits are ignored. Random toggling of the flag write enable exercises both holding and loading of the register.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic p;
    logic z;
    logic s;
    logic v;
  } flag_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] mask, am, bm;
  logic [DATA_W:0]   ext;
  logic              sa, sb, sr;

  always_comb begin
    mask    = wide_i ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {BYTE_W{1'b1}}};
    am      = a_i & mask;
    bm      = b_i & mask;
    ext     = sub_i ? ({1'b0, am} - {1'b0, bm}) : ({1'b0, am} + {1'b0, bm});
    res_o   = ext[DATA_W-1:0] & mask;
    carry_o = wide_i ? ext[DATA_W] : ext[BYTE_W];
    sa      = wide_i ? am[DATA_W-1] : am[BYTE_W-1];
    sb      = wide_i ? bm[DATA_W-1] : bm[BYTE_W-1];
    sr      = wide_i ? res_o[DATA_W-1] : res_o[BYTE_W-1];
    ovf_o   = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o
);
  import alu_status_pkg::*;
  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] mask, raw;

  always_comb begin
    mask = wide_i ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {BYTE_W{1'b1}}};
    case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = '0;
    endcase
    res_o = raw & mask;
  end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]         res_i,
  input  logic                      wide_i,
  input  logic                      arith_i,
  input  logic                      carry_i,
  input  logic                      ovf_i,
  output alu_status_pkg::flag_t     flags_o
);
  always_comb begin
    flags_o.c = arith_i & carry_i;
    flags_o.v = arith_i & ovf_i;
    flags_o.p = ~^res_i[BYTE_W-1:0];
    flags_o.z = wide_i ? (res_i == '0) : (res_i[BYTE_W-1:0] == '0);
    flags_o.s = wide_i ? res_i[DATA_W-1] : res_i[BYTE_W-1];
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  alu_status_pkg::flag_t d_i,
  output alu_status_pkg::flag_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              parity_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              overflow_o
);
  import alu_status_pkg::*;

  logic [DATA_W-1:0] arith_res, logic_res;
  logic              arith_c, arith_v, is_arith, is_sub;
  flag_t             next_flags, cur_flags;

  assign is_sub   = (op_i == OP_SUB);
  assign is_arith = (op_i == OP_ADD) || is_sub;

  alu_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_arith (
    .a_i(opa_i), .b_i(opb_i), .sub_i(is_sub), .wide_i(wide_i),
    .res_o(arith_res), .carry_o(arith_c), .ovf_o(arith_v)
  );

  alu_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_logic (
    .a_i(opa_i), .b_i(opb_i), .op_i(op_i), .wide_i(wide_i), .res_o(logic_res)
  );

  assign result_o = is_arith ? arith_res : logic_res;

  alu_flag_eval #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_eval (
    .res_i(result_o), .wide_i(wide_i), .arith_i(is_arith),
    .carry_i(arith_c), .ovf_i(arith_v), .flags_o(next_flags)
  );

  alu_flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .we_i(flag_we_i), .d_i(next_flags), .q_o(cur_flags)
  );

  assign carry_o    = cur_flags.c;
  assign parity_o   = cur_flags.p;
  assign zero_o     = cur_flags.z;
  assign sign_o     = cur_flags.s;
  assign overflow_o = cur_flags.v;
endmodule

// File: rtl/alu_status_checker.sv
module alu_status_checker #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic              wide_i,
  input logic              flag_we_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              parity_o,
  input logic              zero_o,
  input logic              sign_o,
  input logic              overflow_o
);
  logic res_zero, res_msb;
  assign res_zero = wide_i ? (result_o == '0) : (result_o[BYTE_W-1:0] == '0);
  assign res_msb  = wide_i ? result_o[DATA_W-1] : result_o[BYTE_W-1];

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable({carry_o, parity_o, zero_o, sign_o, overflow_o}));

  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i >= 3'd2) |=> (!carry_o && !overflow_o));

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (zero_o == $past(res_zero)));

  a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (sign_o == $past(res_msb)));

  a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (parity_o == $past(~^result_o[BYTE_W-1:0])));

  a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |-> (result_o[DATA_W-1:BYTE_W] == '0));
endmodule

bind alu_status_unit alu_status_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i), .flag_we_i(flag_we_i),
  .result_o(result_o), .carry_o(carry_o), .parity_o(parity_o), .zero_o(zero_o),
  .sign_o(sign_o), .overflow_o(overflow_o)
);

// File: tb/alu_status_unit_bench.sv
`timescale 1ns/1ps
module alu_status_unit_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] opa = '0, opb = '0;
  logic [2:0]    op = '0;
  logic          wide = 1'b0, we = 1'b0;
  logic [DW-1:0] result;
  logic          c_o, p_o, z_o, s_o, v_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [DW-1:0] res;
    logic [4:0]    fl;   // {c,p,z,s,v}
    string         tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [4:0] model_fl = '0;

  always #5 clk = ~clk;

  alu_status_unit u_alu_status_unit (
    .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
    .wide_i(wide), .flag_we_i(we), .result_o(result), .carry_o(c_o),
    .parity_o(p_o), .zero_o(z_o), .sign_o(s_o), .overflow_o(v_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Independent reference model built from the requirements
  task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [2:0] o,
                       input logic w, output logic [DW-1:0] r, output logic [4:0] f);
    int unsigned wid, modv, am, bm, rv;
    int sa, sb, st;
    logic c, v;
    wid  = w ? 16 : 8;
    modv = 1 << wid;
    am = int'(a) % modv;
    bm = int'(b) % modv;
    c = 0; v = 0;
    sa = (am >= modv/2) ? int'(am) - int'(modv) : int'(am);
    sb = (bm >= modv/2) ? int'(bm) - int'(modv) : int'(bm);
    case (o)
      3'd0: begin rv = (am + bm) % modv; c = (am + bm) >= modv; st = sa + sb;
                  v = (st >= int'(modv/2)) || (st < -int'(modv/2)); end
      3'd1: begin rv = (am + modv - bm) % modv; c = am < bm; st = sa - sb;
                  v = (st >= int'(modv/2)) || (st < -int'(modv/2)); end
      3'd2: rv = am & bm;
      3'd3: rv = am | bm;
      3'd4: rv = am ^ bm;
      default: rv = 0;
    endcase
    r = DW'(rv);
    f = {c, ~^r[7:0], (rv == 0), w ? r[15] : r[7], v};
  endtask

  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [2:0] o,
                       input logic w, input logic e, input string tag);
    exp_t it;
    logic [4:0] f;
    @(negedge clk);
    opa = a; opb = b; op = o; wide = w; we = e;
    model(a, b, o, w, it.res, f);
    if (e) model_fl = f;
    it.fl  = model_fl;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result still reflects the driven inputs 2 ns after the edge; flags updated
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check({it.tag, " result"}, 32'(result), 32'(it.res));
        check({it.tag, " flags cpzsv"}, 32'({c_o, p_o, z_o, s_o, v_o}), 32'(it.fl));
      end
    end
  end

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 flags in reset", 32'({c_o, p_o, z_o, s_o, v_o}), 32'd0);
    rst_n = 1'b1;
    // R3 R6: 8-bit FF+01
    drive(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b1, "R3 R6 8b FF+01");
    // R3: 8-bit 00-01 borrow
    drive(16'h0000, 16'h0001, 3'd1, 1'b0, 1'b1, "R3 8b 00-01 borrow");
    // R4 R7: 8-bit 7F+01
    drive(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b1, "R4 R7 8b 7F+01");
    // R3 R6: 16-bit FFFF+1
    drive(16'hFFFF, 16'h0001, 3'd0, 1'b1, 1'b1, "R3 R6 16b FFFF+1");
    // R4: 16-bit 8000-1
    drive(16'h8000, 16'h0001, 3'd1, 1'b1, 1'b1, "R4 16b 8000-1");
    // R4 R7: 16-bit 7FFF+1
    drive(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b1, "R4 R7 16b 7FFF+1");
    // R5: parity of low byte only in 16-bit mode (result 0300h)
    drive(16'h0200, 16'h0100, 3'd0, 1'b1, 1'b1, "R5 16b low byte parity");
    // R2: upper operand bits ignored in 8-bit mode
    drive(16'hAB12, 16'hCD34, 3'd0, 1'b0, 1'b1, "R2 8b upper ignored");
    // R8 R1: logic ops after a flag-setting op
    drive(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b1, "R3 setup carry");
    drive(16'hF0F0, 16'hFF00, 3'd2, 1'b1, 1'b1, "R1 R8 AND");
    drive(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b1, "R4 setup ovf");
    drive(16'h1234, 16'h8001, 3'd3, 1'b1, 1'b1, "R1 R8 OR");
    drive(16'h00AA, 16'h0055, 3'd4, 1'b0, 1'b1, "R1 R8 XOR");
    drive(16'h1234, 16'h5678, 3'd6, 1'b1, 1'b1, "R1 R8 reserved code");
    // R9: hold when enable low
    drive(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b0, "R9 hold add");
    drive(16'h0000, 16'h0000, 3'd2, 1'b1, 1'b0, "R9 hold zero result");
    // Random mix (R1 R2 R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 400; i++) begin
      drive(16'($urandom), 16'($urandom), 3'($urandom_range(0, 7)),
            1'($urandom), 1'($urandom_range(0, 3) != 0), "R1-mix random");
    end
    @(negedge clk);
    we = 1'b0;
    repeat (3) @(negedge clk);
    // R10: asynchronous clear mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async clear", 32'({c_o, p_o, z_o, s_o, v_o}), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule